// File: doc/BRIEF.md
# Frame-Synchronous Double-Buffered Pixel Store

This block keeps the on/off state of every pixel of a multiplexed segment display in two levels. Software writes the first level, a bank of 32-bit words, through a simple register port whenever it likes. The waveform sequencer reads only the second level, the display copy. This means a half-finished software edit never reaches the glass.

Software asks for its edits to go live by pulsing an update request. The request is held pending until the next frame-start tick. On that tick the whole first level is copied into the display copy in one clock cycle, and the pending state clears. The block keeps two sticky event flags: one that marks every frame start and one that marks a completed transfer. Each flag has its own enable and its own clear input, and the two enabled flags share a single interrupt line.

Top module: `frame_sync_pixbuf`

## Requirements
- R1: While `rst_n` is low at a clock edge, every first-level word, every display word, both flags and the pending state become 0, so `rd_data`, `disp_pixels`, `upd_pending`, `sof_flag`, `done_flag` and `irq` all read 0.
- R2: Word address `2*c + h` holds common line `c` (0 to 7). Half `h=0` covers segments 0 to 31 and `h=1` covers segments 32 to 63, with segment `s` at bit `s mod 32`. A write shows on `rd_data` from the edge that performs it. Display word `k` appears at `disp_pixels[32*k +: 32]`.
- R3: A write to the first level leaves `disp_pixels` unchanged until a transfer takes place.
- R4: `upd_req` sets `upd_pending` from the next edge. It stays 1 until the first tick that finds it already set, and it reads 0 after that tick. A request made while pending has no further effect.
- R5: A tick that finds a request pending replaces all 16 display words in that one edge with the first-level content held before that edge.
- R6: A tick with nothing pending leaves `disp_pixels` and `done_flag` unchanged.
- R7: `done_flag` sets on the edge of each transfer. It clears on an edge where `done_clr` is 1, except that a transfer in the same cycle wins.
- R8: `sof_flag` sets on the edge of every `frame_tick`. It clears on an edge where `sof_clr` is 1, except that a tick in the same cycle wins.
- R9: `irq` is 1 exactly when (`sof_flag` and `sof_ie`) or (`done_flag` and `done_ie`).
- R10: When a write and a transfer fall on the same edge, the display takes the old word and the first level takes the new one.
- R11: A request that arrives in the same cycle as a tick with nothing pending does not transfer on that tick. It is applied on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | First-level write strobe |
| wr_addr | input | 4 | First-level word address |
| wr_data | input | 32 | First-level write data |
| rd_addr | input | 4 | First-level read address |
| rd_data | output | 32 | First-level word at `rd_addr` |
| frame_tick | input | 1 | One-cycle frame-start pulse |
| upd_req | input | 1 | Request to publish the first level |
| sof_clr | input | 1 | Clear the frame-start flag |
| done_clr | input | 1 | Clear the transfer-done flag |
| sof_ie | input | 1 | Frame-start interrupt enable |
| done_ie | input | 1 | Transfer-done interrupt enable |
| upd_pending | output | 1 | Request waiting for a frame start |
| sof_flag | output | 1 | Sticky frame-start flag |
| done_flag | output | 1 | Sticky transfer-done flag |
| irq | output | 1 | Combined interrupt |
| disp_pixels | output | 512 | Display copy, word k at bits 32k+31..32k |

## Verification
Errors in this block show at the ports within one tick of where they arise. A lost or stuck pending state shows at once on `upd_pending`, and on the next tick as a display that fails to change or changes when it should not. A copy taken on the wrong edge, or taken after the write rather than before it, gives a wrong word on `disp_pixels` in the cycle right after the tick. A flag whose set and clear priority is wrong gives a wrong `sof_flag`, `done_flag` or `irq` one edge after the conflicting inputs.

// File: rtl/pixbuf_pkg.sv
// Package: geometry of the pixel store shared by every stage.
// Assumes one bit per pixel and a fixed number of words per common line.
package pixbuf_pkg;
    localparam int COM_MAX       = 8;
    localparam int WORDS_PER_COM = 2;
    localparam int WORD_W        = 32;
    localparam int DEPTH         = COM_MAX * WORDS_PER_COM;
    localparam int ADDR_W        = $clog2(DEPTH);
    localparam int FLAT_W        = DEPTH * WORD_W;
endpackage

// File: rtl/pixbuf_sw_bank.sv
// First-level pixel bank, written and read by software at any time.
// Assumes DEPTH is a power of two so that every address is valid.
module pixbuf_sw_bank #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FLAT_W = DEPTH * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [FLAT_W-1:0] flat_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one word per write strobe; clear the bank on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port for software.
    assign rd_data = mem[rd_addr];

    // Lay the bank out flat for the display copy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat_o[g*WORD_W +: WORD_W] = mem[g];
    end
endmodule

// File: rtl/pixbuf_disp_bank.sv
// Second-level (display) copy of the pixel store.
// Loads every word in one edge when copy_en is high, and holds otherwise.
// Assumes copy_en is a single-cycle qualified frame-start event.
module pixbuf_disp_bank #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int FLAT_W = DEPTH * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              copy_en,
    input  logic [FLAT_W-1:0] src_i,
    output logic [FLAT_W-1:0] disp_o
);
    logic [WORD_W-1:0] disp_q [DEPTH];

    // Parallel load of all words on a transfer; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) disp_q[i] <= '0;
        end else if (copy_en) begin
            for (int i = 0; i < DEPTH; i++) disp_q[i] <= src_i[i*WORD_W +: WORD_W];
        end
    end

    // Present the copy to the waveform sequencer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign disp_o[g*WORD_W +: WORD_W] = disp_q[g];
    end

    AST_HOLD_WITHOUT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_en |=> $stable(disp_o)); // R6
    AST_COPY_TAKES_OLD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> disp_o == $past(src_i)); // R5
endmodule

// File: rtl/pixbuf_upd_ctrl.sv
// Update sequencing and event flags.
// Holds a pending request until a frame tick finds it set, then fires the copy.
// Keeps sticky frame-start and transfer-done flags and combines them into irq.
// Assumes frame_tick is a single-cycle pulse; for each flag, set wins over clear.
module pixbuf_upd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic upd_req,
    input  logic sof_clr,
    input  logic done_clr,
    input  logic sof_ie,
    input  logic done_ie,
    output logic copy_en,
    output logic pending,
    output logic sof_flag,
    output logic done_flag,
    output logic irq
);
    // A transfer needs a request that was already pending before this tick.
    assign copy_en = pending && frame_tick;

    // Pending state: a transfer clears it, otherwise a request sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (copy_en) pending <= 1'b0;
        else if (upd_req) pending <= 1'b1;
    end

    // Frame-start flag: a tick sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          sof_flag <= 1'b0;
        else if (frame_tick) sof_flag <= 1'b1;
        else if (sof_clr)    sof_flag <= 1'b0;
    end

    // Transfer-done flag: a transfer sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (copy_en)  done_flag <= 1'b1;
        else if (done_clr) done_flag <= 1'b0;
    end

    // One interrupt line for both enabled events.
    assign irq = (sof_flag && sof_ie) || (done_flag && done_ie);

    AST_PEND_CLEARS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && frame_tick) |=> !pending); // R4
    AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !frame_tick) |=> pending); // R4
    AST_REQ_NOT_SAME_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && frame_tick && !pending) |=> (pending && $stable(done_flag))); // R11
    AST_DONE_ON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> done_flag); // R7
    AST_SOF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> sof_flag); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_ie && !done_ie) |-> !irq); // R9
endmodule

// File: rtl/frame_sync_pixbuf.sv
// Top: double-buffered pixel store with frame-synchronous publication.
// Software edits the first level freely; the display copy changes only
// on a frame tick after an update request. Assumes a single clock domain.
module frame_sync_pixbuf
    import pixbuf_pkg::*;
#(
    parameter int COMS   = COM_MAX,
    parameter int WPC    = WORDS_PER_COM,
    parameter int WORD_B = WORD_W,
    localparam int DEP   = COMS * WPC,
    localparam int AW    = $clog2(DEP),
    localparam int FW    = DEP * WORD_B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WORD_B-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [WORD_B-1:0] rd_data,
    input  logic          frame_tick,
    input  logic          upd_req,
    input  logic          sof_clr,
    input  logic          done_clr,
    input  logic          sof_ie,
    input  logic          done_ie,
    output logic          upd_pending,
    output logic          sof_flag,
    output logic          done_flag,
    output logic          irq,
    output logic [FW-1:0] disp_pixels
);
    logic [FW-1:0] sw_flat;
    logic          copy_en;

    pixbuf_sw_bank #(.DEPTH(DEP), .WORD_W(WORD_B)) i_sw_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .flat_o(sw_flat)
    );

    pixbuf_disp_bank #(.DEPTH(DEP), .WORD_W(WORD_B)) i_disp_bank (
        .clk(clk), .rst_n(rst_n), .copy_en(copy_en), .src_i(sw_flat),
        .disp_o(disp_pixels)
    );

    pixbuf_upd_ctrl i_upd_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .upd_req(upd_req),
        .sof_clr(sof_clr), .done_clr(done_clr), .sof_ie(sof_ie), .done_ie(done_ie),
        .copy_en(copy_en), .pending(upd_pending), .sof_flag(sof_flag),
        .done_flag(done_flag), .irq(irq)
    );

    AST_WRITE_LEAVES_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frame_tick) |=> $stable(disp_pixels)); // R3
endmodule

// File: tb/test_frame_sync_pixbuf.sv
module test_frame_sync_pixbuf;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        req;
        logic        tick;
        logic [3:0]  chk;
        logic [31:0] exp_disp;
        logic [31:0] exp_sw;
        logic        exp_pend;
    } step_t;

    // Walked from reset with all words zero.
    localparam step_t TABLE [10] = '{
        '{1'b1, 4'd3, 32'hA5A5_0001, 1'b0, 1'b0, 4'd3, 32'h0,         32'hA5A5_0001, 1'b0}, // R3
        '{1'b0, 4'd0, 32'h0,         1'b0, 1'b1, 4'd3, 32'h0,         32'hA5A5_0001, 1'b0}, // R6
        '{1'b0, 4'd0, 32'h0,         1'b1, 1'b0, 4'd3, 32'h0,         32'hA5A5_0001, 1'b1}, // R4
        '{1'b1, 4'd5, 32'h1234_5678, 1'b0, 1'b0, 4'd3, 32'h0,         32'hA5A5_0001, 1'b1}, // R3
        '{1'b0, 4'd0, 32'h0,         1'b0, 1'b1, 4'd3, 32'hA5A5_0001, 32'hA5A5_0001, 1'b0}, // R5
        '{1'b0, 4'd0, 32'h0,         1'b0, 1'b0, 4'd5, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R5
        '{1'b1, 4'd3, 32'hFFFF_0000, 1'b1, 1'b0, 4'd3, 32'hA5A5_0001, 32'hFFFF_0000, 1'b1}, // R4
        '{1'b1, 4'd3, 32'h0000_FFFF, 1'b0, 1'b1, 4'd3, 32'hFFFF_0000, 32'h0000_FFFF, 1'b0}, // R10
        '{1'b0, 4'd0, 32'h0,         1'b1, 1'b1, 4'd3, 32'hFFFF_0000, 32'h0000_FFFF, 1'b1}, // R11
        '{1'b0, 4'd0, 32'h0,         1'b0, 1'b1, 4'd3, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0}  // R11
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         frame_tick = 1'b0;
    logic         upd_req = 1'b0;
    logic         sof_clr = 1'b0;
    logic         done_clr = 1'b0;
    logic         sof_ie = 1'b0;
    logic         done_ie = 1'b0;
    logic         upd_pending, sof_flag, done_flag, irq;
    logic [511:0] disp_pixels;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    frame_sync_pixbuf i_frame_sync_pixbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_tick(frame_tick), .upd_req(upd_req),
        .sof_clr(sof_clr), .done_clr(done_clr), .sof_ie(sof_ie), .done_ie(done_ie),
        .upd_pending(upd_pending), .sof_flag(sof_flag), .done_flag(done_flag),
        .irq(irq), .disp_pixels(disp_pixels)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; upd_req = 1'b0; frame_tick = 1'b0;
        sof_clr = 1'b0; done_clr = 1'b0;
    endtask

    task automatic cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    logic [31:0] pattern [16];

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 disp", disp_pixels, '0);
        chk("R1 rd", rd_data, '0);
        chk("R1 flags", {upd_pending, sof_flag, done_flag, irq}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            wr_en = TABLE[i].wr; wr_addr = TABLE[i].addr; wr_data = TABLE[i].data;
            upd_req = TABLE[i].req; frame_tick = TABLE[i].tick; rd_addr = TABLE[i].chk;
            @(negedge clk);
            chk($sformatf("R5/R10 step%0d disp", i), disp_pixels[TABLE[i].chk*32 +: 32], TABLE[i].exp_disp);
            chk($sformatf("R2 step%0d rd", i), rd_data, TABLE[i].exp_sw);
            chk($sformatf("R4/R11 step%0d pend", i), upd_pending, TABLE[i].exp_pend);
        end
        idle_inputs();
        chk("R3 untouched word0", disp_pixels[31:0], '0);

        // R9: flags set, enables off
        @(negedge clk);
        chk("R9 masked", {sof_flag, done_flag, irq}, 3'b110);
        sof_clr = 1'b1; done_clr = 1'b1; cycle();
        chk("R7/R8 clear", {sof_flag, done_flag}, 2'b00);
        sof_ie = 1'b1; frame_tick = 1'b1; cycle();
        chk("R8 sof set", sof_flag, 1'b1);
        chk("R9 irq sof", irq, 1'b1);
        chk("R6 no done", done_flag, 1'b0);
        frame_tick = 1'b1; sof_clr = 1'b1; cycle();
        chk("R8 set wins", sof_flag, 1'b1);
        sof_clr = 1'b1; cycle();
        chk("R8 cleared", {sof_flag, irq}, 2'b00);

        // R7 set wins over clear; R9 via done
        sof_ie = 1'b0; done_ie = 1'b1;
        upd_req = 1'b1; cycle();
        frame_tick = 1'b1; done_clr = 1'b1; cycle();
        chk("R7 set wins", done_flag, 1'b1);
        chk("R9 irq done", irq, 1'b1);
        chk("R9 sof flag on but masked", sof_flag, 1'b1);
        done_clr = 1'b1; cycle();
        chk("R7 cleared", {done_flag, irq}, 2'b00);

        // R2: com 6, segment 40 -> word 13 bit 8
        wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h0000_0100; rd_addr = 4'd13; cycle();
        chk("R2 readback", rd_data, 32'h0000_0100);
        upd_req = 1'b1; cycle();
        frame_tick = 1'b1; cycle();
        chk("R2 disp bit", disp_pixels[13*32+8], 1'b1);
        chk("R2 neighbour", disp_pixels[12*32+8], 1'b0);

        // R5: fill all words, none visible before tick, all after
        for (int w = 0; w < 16; w++) begin
            pattern[w] = 32'hC0DE_0000 + 32'(w * 17);
            wr_en = 1'b1; wr_addr = 4'(w); wr_data = pattern[w];
            cycle();
        end
        chk("R3 pre tick word13", disp_pixels[13*32 +: 32], 32'h0000_0100);
        upd_req = 1'b1; cycle();
        upd_req = 1'b1; cycle();
        chk("R4 repeat req", upd_pending, 1'b1);
        frame_tick = 1'b1; cycle();
        for (int w = 0; w < 16; w++)
            chk($sformatf("R5 word%0d", w), disp_pixels[w*32 +: 32], pattern[w]);
        chk("R4 single transfer", upd_pending, 1'b0);
        frame_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h1; cycle();
        chk("R6 tick no pending", disp_pixels[31:0], pattern[0]);

        // R1: reset mid-run
        upd_req = 1'b1; cycle();
        rst_n = 1'b0; cycle();
        rd_addr = 4'd0;
        #1;
        chk("R1 mid disp", disp_pixels, '0);
        chk("R1 mid state", {upd_pending, sof_flag, done_flag, irq, rd_data}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule